// File: doc/BRIEF.md
# TLB Refill Fault Recorder

This block holds the state a software refill handler needs after an address translation fault. When the lookup logic reports a fault, the block captures three things in one clock edge. The first is which TLB slot the handler should write: the index comes from the faulting page, and the way is either the way that matched or a pseudo-random way. The second is a fault-cause word built from the process ID, the access type and the virtual page number. The third is the next state of the pseudo-random sequence.

A 16-bit shift register supplies the replacement way. It shifts right, and a parity feedback bit enters at the top. It starts from a fixed seed after reset and moves only on faults that are real and not debug probes. For a full miss, the two low bits of the register as it stood before the fault pick the way. For a permission fault on a hit, the matching way is recorded. A debug probe that faults leaves every register untouched. Software reads the cause word, the select word and the random register through a small combinational read port.

Inside, an event decoder sorts each cycle into one of four named events using a unique case: EV_IDLE (no fault strobe), EV_PROBE (a fault during a debug probe), EV_REFILL (a fault on a miss) and EV_PERM (a fault on a hit). Only EV_REFILL and EV_PERM write the registers. The block holds no other state, so no event depends on an earlier one. Every cycle goes back through the decoder.

Top module: `tlb_fault_recorder`

## Requirements
- R1: A synchronous reset sets the random register to 0xCCCC and clears the cause and select registers.
- R2: When the random register advances, its new value is the old value shifted right by one. Bit 15 receives the parity (XOR reduction) of the old value ANDed with 0x8805.
- R3: The random register advances only in a cycle where fault_i is high and debug_i is low. In every other cycle it keeps its value.
- R4: On a recorded fault with hit_i low, the way written to the select register equals bits [1:0] of the random register before it advances.
- R5: On a recorded fault with hit_i high, the way written to the select register equals hit_way_i.
- R6: On a recorded fault, the select register is rewritten whole: bits [3:0] take vpn_i[3:0], bits [5:4] take the way, and all higher bits read as zero.
- R7: On a recorded fault, cause bits [7:0] take pid_i, bits [9:8] take acc_i and bits [31:13] take vpn_i. Bits [12:10] keep their previous value, which is zero from reset.
- R8: When fault_i is low, or when fault_i and debug_i are both high, the cause and select registers keep their values.
- R9: The read port is combinational. rd_addr_i 0 returns the cause register, 1 the select register zero-extended, 2 the random register zero-extended, and 3 returns zero.
- R10: Access types are encoded as read=0, write=1 and execute=2, and each is recorded unchanged in cause bits [9:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fault_i | input | 1 | Translation fault strobe for this cycle |
| debug_i | input | 1 | The faulting lookup was a debug probe; nothing is recorded |
| hit_i | input | 1 | A TLB entry matched (permission fault) rather than a full miss |
| hit_way_i | input | 2 | Way of the matching entry, used when hit_i is high |
| vpn_i | input | 19 | Virtual page number of the faulting access |
| pid_i | input | 8 | Current process ID |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rd_addr_i | input | 2 | Read-back register select |
| rd_data_o | output | 32 | Read-back data for rd_addr_i |

## Verification
The bench goes after the boundary between EV_PROBE and the recording events. If the design advanced the random register on a debug probe, it would give a different refill way sequence from that point on, and the shadow model would notice on the next miss. It checks that a miss samples the random register before the shift: a design that used the shifted value would write the wrong way on almost every refill. It also checks a permission fault whose matching way differs from the random bits, so that a design choosing the wrong way source would write the wrong select value. A long run of misses compares the full 16-bit sequence against a parity model. That catches a wrong tap or a wrong shift direction within a few steps. A reset in the middle of the run confirms the seed is restored.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } access_e;

    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_PROBE  = 2'd1,
        EV_REFILL = 2'd2,
        EV_PERM   = 2'd3
    } fault_event_e;

    localparam int RD_CAUSE  = 0;
    localparam int RD_SELECT = 1;
    localparam int RD_RANDOM = 2;

endpackage

// File: rtl/tfr_event_decode.sv
module tfr_event_decode
    import tfr_pkg::*;
#(
    parameter int WAY_W = 2
) (
    input  logic             fault,
    input  logic             debug,
    input  logic             hit,
    input  logic [WAY_W-1:0] hit_way,
    input  logic [WAY_W-1:0] rand_way,
    output fault_event_e     event_o,
    output logic             record_o,
    output logic [WAY_W-1:0] way_o
);

    always_comb begin
        if (!fault) begin
            event_o = EV_IDLE;
        end else if (debug) begin
            event_o = EV_PROBE;
        end else if (hit) begin
            event_o = EV_PERM;
        end else begin
            event_o = EV_REFILL;
        end
    end

    always_comb begin
        record_o = 1'b0;
        way_o    = '0;
        unique case (event_o)
            EV_IDLE: begin
                record_o = 1'b0;
            end
            EV_PROBE: begin
                record_o = 1'b0;
            end
            EV_REFILL: begin
                record_o = 1'b1;
                way_o    = rand_way;
            end
            EV_PERM: begin
                record_o = 1'b1;
                way_o    = hit_way;
            end
        endcase
    end

endmodule

// File: rtl/tfr_lfsr.sv
module tfr_lfsr #(
    parameter int           WIDTH = 16,
    parameter logic [WIDTH-1:0] SEED  = 16'hCCCC,
    parameter logic [WIDTH-1:0] TAPS  = 16'h8805
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] state_q;
    logic             feedback;

    assign feedback = ^(state_q & TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= {feedback, state_q[WIDTH-1:1]};
        end
    end

    assign value = state_q;

endmodule

// File: rtl/tfr_fault_regs.sv
module tfr_fault_regs #(
    parameter int WAY_W   = 2,
    parameter int IDX_W   = 4,
    parameter int VPN_W   = 19,
    parameter int PID_W   = 8,
    parameter int ACC_W   = 2,
    parameter int CAUSE_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   record,
    input  logic [WAY_W-1:0]       way,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [PID_W-1:0]       pid,
    input  logic [ACC_W-1:0]       acc,
    output logic [CAUSE_W-1:0]     cause,
    output logic [IDX_W+WAY_W-1:0] select
);

    localparam int ACC_LSB = PID_W;
    localparam int VPN_LSB = CAUSE_W - VPN_W;

    logic [CAUSE_W-1:0]     cause_q;
    logic [IDX_W+WAY_W-1:0] select_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q  <= '0;
            select_q <= '0;
        end else if (record) begin
            select_q                   <= {way, vpn[IDX_W-1:0]};
            cause_q[PID_W-1:0]         <= pid;
            cause_q[ACC_LSB +: ACC_W]  <= acc;
            cause_q[VPN_LSB +: VPN_W]  <= vpn;
        end
    end

    assign cause  = cause_q;
    assign select = select_q;

endmodule

// File: rtl/tlb_fault_recorder.sv
module tlb_fault_recorder
    import tfr_pkg::*;
#(
    parameter int               LFSR_W  = 16,
    parameter logic [LFSR_W-1:0] SEED   = 16'hCCCC,
    parameter logic [LFSR_W-1:0] TAPS   = 16'h8805,
    parameter int               WAY_W   = 2,
    parameter int               IDX_W   = 4,
    parameter int               VPN_W   = 19,
    parameter int               PID_W   = 8,
    parameter int               ACC_W   = 2,
    parameter int               DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_i,
    input  logic              debug_i,
    input  logic              hit_i,
    input  logic [WAY_W-1:0]  hit_way_i,
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [PID_W-1:0]  pid_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int SEL_W = IDX_W + WAY_W;

    logic [LFSR_W-1:0] rnd_q;
    logic [DATA_W-1:0] cause_q;
    logic [SEL_W-1:0]  sel_q;
    logic              record;
    logic [WAY_W-1:0]  way;
    fault_event_e      cur_event;

    tfr_event_decode #(
        .WAY_W (WAY_W)
    ) u_decode (
        .fault    (fault_i),
        .debug    (debug_i),
        .hit      (hit_i),
        .hit_way  (hit_way_i),
        .rand_way (rnd_q[WAY_W-1:0]),
        .event_o  (cur_event),
        .record_o (record),
        .way_o    (way)
    );

    tfr_lfsr #(
        .WIDTH (LFSR_W),
        .SEED  (SEED),
        .TAPS  (TAPS)
    ) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (record),
        .value (rnd_q)
    );

    tfr_fault_regs #(
        .WAY_W   (WAY_W),
        .IDX_W   (IDX_W),
        .VPN_W   (VPN_W),
        .PID_W   (PID_W),
        .ACC_W   (ACC_W),
        .CAUSE_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .record (record),
        .way    (way),
        .vpn    (vpn_i),
        .pid    (pid_i),
        .acc    (acc_i),
        .cause  (cause_q),
        .select (sel_q)
    );

    always_comb begin
        unique case (rd_addr_i)
            2'(RD_CAUSE):  rd_data_o = cause_q;
            2'(RD_SELECT): rd_data_o = {{(DATA_W-SEL_W){1'b0}}, sel_q};
            2'(RD_RANDOM): rd_data_o = {{(DATA_W-LFSR_W){1'b0}}, rnd_q};
            default:       rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/tfr_checker.sv
module tfr_checker #(
    parameter int               LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS  = 16'h8805,
    parameter int               WAY_W  = 2,
    parameter int               IDX_W  = 4,
    parameter int               VPN_W  = 19,
    parameter int               PID_W  = 8,
    parameter int               ACC_W  = 2,
    parameter int               DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fault,
    input  logic                   debug,
    input  logic                   hit,
    input  logic [WAY_W-1:0]       hit_way,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [PID_W-1:0]       pid,
    input  logic [LFSR_W-1:0]      rnd,
    input  logic [DATA_W-1:0]      cause,
    input  logic [IDX_W+WAY_W-1:0] sel
);

    localparam int ACC_LSB = PID_W;
    localparam int GAP_LSB = PID_W + ACC_W;
    localparam int VPN_LSB = DATA_W - VPN_W;

    logic rec;
    assign rec = fault && !debug;

    a_r2_step_value: assert property (@(posedge clk) disable iff (rst)
        rec |=> rnd == {^($past(rnd) & TAPS), $past(rnd[LFSR_W-1:1])});

    a_r2_never_zero: assert property (@(posedge clk) disable iff (rst)
        rnd != '0);

    a_r3_hold_random: assert property (@(posedge clk) disable iff (rst)
        !rec |=> $stable(rnd));

    a_r4_refill_way: assert property (@(posedge clk) disable iff (rst)
        (rec && !hit) |=> sel[IDX_W +: WAY_W] == $past(rnd[WAY_W-1:0]));

    a_r5_perm_way: assert property (@(posedge clk) disable iff (rst)
        (rec && hit) |=> sel[IDX_W +: WAY_W] == $past(hit_way));

    a_r6_index: assert property (@(posedge clk) disable iff (rst)
        rec |=> sel[IDX_W-1:0] == $past(vpn[IDX_W-1:0]));

    a_r7_pid: assert property (@(posedge clk) disable iff (rst)
        rec |=> cause[PID_W-1:0] == $past(pid));

    a_r7_vpn: assert property (@(posedge clk) disable iff (rst)
        rec |=> cause[VPN_LSB +: VPN_W] == $past(vpn));

    a_r7_gap_zero: assert property (@(posedge clk) disable iff (rst)
        cause[VPN_LSB-1:GAP_LSB] == '0);

    a_r8_hold_regs: assert property (@(posedge clk) disable iff (rst)
        !rec |=> ($stable(cause) && $stable(sel)));

endmodule

bind tlb_fault_recorder tfr_checker #(
    .LFSR_W (LFSR_W),
    .TAPS   (TAPS),
    .WAY_W  (WAY_W),
    .IDX_W  (IDX_W),
    .VPN_W  (VPN_W),
    .PID_W  (PID_W),
    .ACC_W  (ACC_W),
    .DATA_W (DATA_W)
) u_checker (
    .clk     (clk),
    .rst     (rst),
    .fault   (fault_i),
    .debug   (debug_i),
    .hit     (hit_i),
    .hit_way (hit_way_i),
    .vpn     (vpn_i),
    .pid     (pid_i),
    .rnd     (rnd_q),
    .cause   (cause_q),
    .sel     (sel_q)
);

// File: tb/tlb_fault_recorder_test.sv
module tlb_fault_recorder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fault_i = 1'b0;
    logic        debug_i = 1'b0;
    logic        hit_i = 1'b0;
    logic [1:0]  hit_way_i = '0;
    logic [18:0] vpn_i = '0;
    logic [7:0]  pid_i = '0;
    logic [1:0]  acc_i = '0;
    logic [1:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // shadow model state
    int unsigned m_rnd;
    int unsigned m_cause;
    int unsigned m_sel;

    always #10 clk = ~clk;

    tlb_fault_recorder uut (
        .clk       (clk),
        .rst       (rst),
        .fault_i   (fault_i),
        .debug_i   (debug_i),
        .hit_i     (hit_i),
        .hit_way_i (hit_way_i),
        .vpn_i     (vpn_i),
        .pid_i     (pid_i),
        .acc_i     (acc_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic read_reg(input int a, output int unsigned v);
        rd_addr_i = 2'(a);
        #1;
        v = rd_data_o;
    endtask

    task automatic compare_all();
        int unsigned v;
        read_reg(0, v); chk("R7 cause", v, m_cause);
        read_reg(1, v); chk("R6 select", v, m_sel);
        read_reg(2, v); chk("R2 random", v, m_rnd);
    endtask

    function automatic int unsigned next_rnd(input int unsigned r);
        int unsigned f = 0;
        for (int i = 0; i < 16; i++) begin
            f = f ^ (((r >> i) & 1) & ((32'h8805 >> i) & 1));
        end
        return ((r >> 1) | (f << 15)) & 32'hFFFF;
    endfunction

    function automatic void model_update();
        int unsigned way;
        if (rst) begin
            m_rnd = 32'hCCCC; m_cause = 0; m_sel = 0;
        end else if (fault_i && !debug_i) begin
            way = hit_i ? int'(hit_way_i) : (m_rnd & 3);
            m_sel = (way << 4) | (vpn_i & 32'hF);
            m_cause = (m_cause & 32'h00001C00) | (int'(vpn_i) << 13)
                      | (int'(acc_i) << 8) | int'(pid_i);
            m_rnd = next_rnd(m_rnd);
        end
    endfunction

    // Drive at negedge, update model at posedge, compare at next negedge.
    task automatic cycle(input bit f, input bit d, input bit h, input int hw,
                         input int vpn, input int pid, input int acc);
        fault_i = f; debug_i = d; hit_i = h; hit_way_i = 2'(hw);
        vpn_i = 19'(vpn); pid_i = 8'(pid); acc_i = 2'(acc);
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned v;
        int unsigned pre;
        m_rnd = 32'hCCCC; m_cause = 0; m_sel = 0;
        @(negedge clk);
        rst = 1'b1;
        cycle(0, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0);
        // R1: reset state
        read_reg(2, v); chk("R1 seed", v, 32'hCCCC);
        read_reg(0, v); chk("R1 cause clear", v, 0);
        read_reg(1, v); chk("R1 select clear", v, 0);
        rst = 1'b0;
        cycle(0, 0, 0, 0, 0, 0, 0);
        // R9: unused address reads zero
        read_reg(3, v); chk("R9 addr3", v, 0);

        // R4: miss uses pre-advance random bits (0xCCCC -> way 0)
        pre = m_rnd;
        cycle(1, 0, 0, 3, 19'h12345, 8'hA5, 0);
        read_reg(1, v); chk("R4 refill way", (v >> 4) & 3, pre & 3);
        read_reg(0, v); chk("R10 read code", (v >> 8) & 3, 0);
        read_reg(2, v); chk("R2 one step", v, next_rnd(32'hCCCC));

        // R3 / R8: debug probe fault changes nothing
        pre = m_rnd;
        cycle(1, 1, 0, 0, 19'h7FFFF, 8'hFF, 2);
        read_reg(2, v); chk("R3 probe hold random", v, pre);
        read_reg(0, v); chk("R8 probe hold cause", v, m_cause);
        cycle(1, 1, 1, 2, 19'h00001, 8'h01, 1);
        read_reg(1, v); chk("R8 probe-hit hold select", v, m_sel);

        // R3 / R8: idle cycles with busy inputs
        cycle(0, 0, 1, 3, 19'h55555, 8'h3C, 1);
        read_reg(2, v); chk("R3 idle hold random", v, pre);

        // R5: permission fault records matched way, differs from random
        pre = m_rnd;
        cycle(1, 0, 1, int'((pre & 3) ^ 3), 19'h0ABCD, 8'h42, 1);
        read_reg(1, v); chk("R5 hit way", (v >> 4) & 3, (pre & 3) ^ 3);
        read_reg(0, v); chk("R10 write code", (v >> 8) & 3, 1);
        read_reg(1, v); chk("R6 index", v & 15, 32'hD);

        // R10: execute code, full-width vpn
        cycle(1, 0, 0, 0, 19'h7FFFF, 8'h00, 2);
        read_reg(0, v); chk("R10 exec code", (v >> 8) & 3, 2);
        read_reg(0, v); chk("R7 gap bits zero", v & 32'h1C00, 0);
        read_reg(0, v); chk("R7 vpn field", v >> 13, 32'h7FFFF);

        // Long run of mixed faults to walk the random sequence
        for (int i = 0; i < 300; i++) begin
            cycle(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
                  int'($urandom % 4), int'($urandom % 524288), int'($urandom % 256),
                  int'($urandom % 3));
        end

        // R1: reset in the middle restores the seed
        rst = 1'b1;
        cycle(1, 0, 0, 0, 19'h00FF0, 8'h11, 1);
        read_reg(2, v); chk("R1 mid-run seed", v, 32'hCCCC);
        rst = 1'b0;
        pre = m_rnd;
        cycle(1, 0, 0, 0, 19'h00003, 8'h22, 0);
        read_reg(1, v); chk("R4 after reset", v, ((pre & 3) << 4) | 3);

        for (int i = 0; i < 40; i++) begin
            cycle(1, 0, 0, 0, i, i, 0);
        end
        finish_run();
    end

endmodule